// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Sequencer

This block is the digital protection sequencer of a synchronous step-down converter. It watches comparator flags from the analog front end and decides when the high-side switch must be cut and when every power switch must be turned off. It also handles the output discharge path, soft-start retries, the low-ripple pulse-skipping mode and the fault indication. Switching cycles are marked by a one-clock tick. A cycle that sees an overcurrent event cuts the high-side switch for the rest of that cycle. A long unbroken run of such cycles shuts the converter down for a fixed hiccup interval, after which a fresh soft-start is requested.

A second, independent path guards against excessive reverse inductor current. Several back-to-back cycles with the valley current beyond the negative limit turn all switches off and close the discharge switch. Switching resumes once the output is back in regulation, and pulse-skipping mode is then held for a timed window. An over-temperature flag overrides everything. It holds the converter off until the flag clears and then restarts through soft-start. All timer lengths and trip counts are parameters in clock cycles or switching cycles.

Top module: `hiccup_fault_seq`

## Requirements
- R1: Out of reset the block is in soft-start: `force_pfm`=1 and `hs_kill`, `all_off`, `dis_en`, `ss_restart` and `fault` are all 0.
- R2: While switching is allowed, `oc_flag` raises `hs_kill` in the same clock. `hs_kill` then stays high until the clock in which `cyc_tick` is sampled, and is released after that edge unless `oc_flag` is still high.
- R3: A switching cycle is closed by the clock that samples `cyc_tick`=1, and it counts as an overcurrent cycle if `oc_flag` was seen at any clock since the previous tick. A closed cycle without overcurrent clears the consecutive count, so 16 overcurrent cycles, one clean cycle and 16 more do not shut down.
- R4: The 17th consecutive overcurrent cycle (OC_TRIP) shuts down: from the next clock `all_off`, `hs_kill` and `fault` are 1.
- R5: After an overcurrent shutdown the block stays off for HICCUP_PERIODS x SS_PERIOD_CLKS clocks (default 8 x 16 = 128). It then issues a one-clock `ss_restart` pulse, and `fault` drops in that same clock while `force_pfm` rises.
- R6: In soft-start, a `ss_done` pulse moves the block to normal run, where `force_pfm` is 0.
- R7: In normal run only, NEG_TRIP (4) consecutive closed cycles with `neg_flag`=1 set `all_off` and `dis_en` with `fault`=0. A cycle without `neg_flag` clears the count, and `neg_flag` has no effect during soft-start.
- R8: The discharge state lasts until `in_reg`=1 is sampled. `force_pfm` is then held for PFM_HOLD_CLKS clocks (default 20), after which normal run resumes with `force_pfm`=0.
- R9: `ot_flag`=1 sets `all_off` and `fault` from the next clock, in any state. When it is sampled low again, `ss_restart` pulses, `fault` drops and soft-start begins.
- R10: Over-temperature takes priority over the hiccup wait: if it clears before the wait ends, the restart follows at once, without the remaining wait.
- R11: Counters start fresh after a retry: 16 overcurrent cycles right after a hiccup restart do not shut down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock pulse closing a switching cycle |
| oc_flag | input | 1 | Positive peak-current comparator |
| neg_flag | input | 1 | Valley current beyond negative limit |
| in_reg | input | 1 | Output within regulation window |
| ot_flag | input | 1 | Over-temperature comparator |
| ss_done | input | 1 | Soft-start ramp completed pulse |
| hs_kill | output | 1 | High-side switch must be off |
| all_off | output | 1 | Both power switches off |
| dis_en | output | 1 | Output discharge switch on |
| ss_restart | output | 1 | One-clock soft-start request |
| force_pfm | output | 1 | Hold pulse-skipping mode |
| fault | output | 1 | Shutdown fault active |

## Verification
Overcurrent counting is tried with four patterns. A mid-cycle pulse that must be latched to the tick tells the per-cycle latch apart from a tick-only sample. A pulse coincident with the tick is also tried. A 16-clean-16 run separates a consecutive count from a cumulative one, and a full 17-cycle run locates the exact trip. The hiccup wait is counted clock by clock, and a restart followed by 16 more overcurrent cycles shows whether the counters were cleared. Negative-current runs of 3-gap-3-1 and a burst during soft-start separate run-only, consecutive counting from the alternatives, and over-temperature is applied both in normal run and during the hiccup wait.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

    typedef enum logic [2:0] {
        ST_SOFT    = 3'd0,
        ST_RUN     = 3'd1,
        ST_OC_WAIT = 3'd2,
        ST_NEG_DIS = 3'd3,
        ST_NEG_PFM = 3'd4,
        ST_OT_OFF  = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic hs_kill;
        logic all_off;
        logic dis_en;
        logic ss_restart;
        logic force_pfm;
        logic fault;
    } seq_out_t;

    function automatic logic st_is_off(seq_state_t s);
        return (s == ST_OC_WAIT) || (s == ST_NEG_DIS) || (s == ST_OT_OFF);
    endfunction

    function automatic logic st_is_fault(seq_state_t s);
        return (s == ST_OC_WAIT) || (s == ST_OT_OFF);
    endfunction

endpackage

// File: rtl/hcp_latch.sv
// Holds an overcurrent hit until the switching cycle closes.
module hcp_latch (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic oc,
    output logic kill,
    output logic hit
);
    logic held;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            held <= 1'b0;
        end else begin
            held <= (held | oc) & ~tick;
        end
    end

    assign hit  = held | oc;
    assign kill = en & (held | oc);
endmodule

// File: rtl/hcp_consec.sv
// Counts consecutive closed cycles with a hit; pulses trip on the LIMIT-th.
module hcp_consec #(
    parameter int LIMIT = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  logic hit,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    assign trip = en & tick & hit & (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            if (hit && !trip) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/hcp_timer.sv
// Runs while run is high; done marks the LEN-th clock of a run.
module hcp_timer #(
    parameter int LEN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int TW = $clog2(LEN + 1);
    logic [TW-1:0] cnt;

    assign done = run & (cnt == TW'(LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hiccup_fault_seq.sv
module hiccup_fault_seq
    import hcp_pkg::*;
#(
    parameter int OC_TRIP        = 17,
    parameter int NEG_TRIP       = 4,
    parameter int SS_PERIOD_CLKS = 16,
    parameter int HICCUP_PERIODS = 8,
    parameter int PFM_HOLD_CLKS  = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_tick,
    input  logic oc_flag,
    input  logic neg_flag,
    input  logic in_reg,
    input  logic ot_flag,
    input  logic ss_done,
    output logic hs_kill,
    output logic all_off,
    output logic dis_en,
    output logic ss_restart,
    output logic force_pfm,
    output logic fault
);
    localparam int WAIT_CLKS = HICCUP_PERIODS * SS_PERIOD_CLKS;

    seq_state_t st, st_nxt;
    logic       req_q, req_nxt;
    logic       sw_ok, oc_kill, oc_hit, oc_trip, neg_trip;
    logic       hic_done, pfm_done;
    seq_out_t   o;

    assign sw_ok = !st_is_off(st);

    hcp_latch u_oc_latch (
        .clk(clk), .rst(rst), .en(sw_ok), .tick(cyc_tick),
        .oc(oc_flag), .kill(oc_kill), .hit(oc_hit)
    );

    hcp_consec #(.LIMIT(OC_TRIP)) u_oc_cnt (
        .clk(clk), .rst(rst), .en(sw_ok), .tick(cyc_tick),
        .hit(oc_hit), .trip(oc_trip)
    );

    hcp_consec #(.LIMIT(NEG_TRIP)) u_neg_cnt (
        .clk(clk), .rst(rst), .en(st == ST_RUN), .tick(cyc_tick),
        .hit(neg_flag), .trip(neg_trip)
    );

    hcp_timer #(.LEN(WAIT_CLKS)) u_hic_tmr (
        .clk(clk), .rst(rst), .run(st == ST_OC_WAIT), .done(hic_done)
    );

    hcp_timer #(.LEN(PFM_HOLD_CLKS)) u_pfm_tmr (
        .clk(clk), .rst(rst), .run(st == ST_NEG_PFM), .done(pfm_done)
    );

    always_comb begin
        st_nxt  = st;
        req_nxt = 1'b0;
        if (ot_flag) begin
            st_nxt = ST_OT_OFF;
        end else begin
            unique case (st)
                ST_SOFT: begin
                    if (oc_trip)      st_nxt = ST_OC_WAIT;
                    else if (ss_done) st_nxt = ST_RUN;
                end
                ST_RUN: begin
                    if (oc_trip)       st_nxt = ST_OC_WAIT;
                    else if (neg_trip) st_nxt = ST_NEG_DIS;
                end
                ST_OC_WAIT: begin
                    if (hic_done) begin
                        st_nxt  = ST_SOFT;
                        req_nxt = 1'b1;
                    end
                end
                ST_NEG_DIS: begin
                    if (in_reg) st_nxt = ST_NEG_PFM;
                end
                ST_NEG_PFM: begin
                    if (oc_trip)       st_nxt = ST_OC_WAIT;
                    else if (pfm_done) st_nxt = ST_RUN;
                end
                ST_OT_OFF: begin
                    st_nxt  = ST_SOFT;
                    req_nxt = 1'b1;
                end
                default: st_nxt = ST_SOFT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_SOFT;
            req_q <= 1'b0;
        end else begin
            st    <= st_nxt;
            req_q <= req_nxt;
        end
    end

    always_comb begin
        o.all_off    = st_is_off(st);
        o.hs_kill    = o.all_off | oc_kill;
        o.dis_en     = (st == ST_NEG_DIS);
        o.ss_restart = req_q;
        o.force_pfm  = (st == ST_SOFT) || (st == ST_NEG_PFM);
        o.fault      = st_is_fault(st);
    end

    assign hs_kill    = o.hs_kill;
    assign all_off    = o.all_off;
    assign dis_en     = o.dis_en;
    assign ss_restart = o.ss_restart;
    assign force_pfm  = o.force_pfm;
    assign fault      = o.fault;
endmodule

// File: rtl/hcp_chk.sv
module hcp_chk (
    input logic clk,
    input logic rst,
    input logic cyc_tick,
    input logic oc_flag,
    input logic ot_flag,
    input logic hs_kill,
    input logic all_off,
    input logic dis_en,
    input logic ss_restart,
    input logic fault
);
    // R2
    oc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (oc_flag && !cyc_tick && !ot_flag) |=> hs_kill);

    // R4
    fault_off_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (all_off && hs_kill));

    // R5
    restart_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ss_restart |=> !ss_restart);

    // R5
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ss_restart |-> (!fault && !all_off));

    // R8
    discharge_off_chk: assert property (@(posedge clk) disable iff (rst)
        dis_en |-> (all_off && !fault));

    // R9
    hot_off_chk: assert property (@(posedge clk) disable iff (rst)
        ot_flag |=> (all_off && fault));
endmodule

bind hiccup_fault_seq hcp_chk u_hcp_chk (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .oc_flag(oc_flag),
    .ot_flag(ot_flag), .hs_kill(hs_kill), .all_off(all_off),
    .dis_en(dis_en), .ss_restart(ss_restart), .fault(fault)
);

// File: tb/tb_hiccup_fault_seq.sv
module tb_hiccup_fault_seq;
    localparam int OC_N   = 17;
    localparam int NEG_N  = 4;
    localparam int WAIT_N = 8 * 16;
    localparam int PFM_N  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_tick = 0, oc_flag = 0, neg_flag = 0, in_reg = 0, ot_flag = 0, ss_done = 0;
    logic hs_kill, all_off, dis_en, ss_restart, force_pfm, fault;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 0;

    always #5 clk = ~clk;

    hiccup_fault_seq dut (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .oc_flag(oc_flag),
        .neg_flag(neg_flag), .in_reg(in_reg), .ot_flag(ot_flag),
        .ss_done(ss_done), .hs_kill(hs_kill), .all_off(all_off),
        .dis_en(dis_en), .ss_restart(ss_restart), .force_pfm(force_pfm),
        .fault(fault)
    );

    // outputs packed as {hs_kill, all_off, dis_en, ss_restart, force_pfm, fault}
    function automatic logic [5:0] outs();
        return {hs_kill, all_off, dis_en, ss_restart, force_pfm, fault};
    endfunction

    // inputs {tick, oc, neg, in_reg, ot, ss_done} then expected outputs
    localparam logic [11:0] VEC [10] = '{
        12'b000000_000010,  // R1 idle in soft-start
        12'b000001_000000,  // R6 ss_done -> run
        12'b010000_100000,  // R2 oc mid-cycle
        12'b000000_100000,  // R2 held until tick
        12'b100000_000000,  // R2 released after tick
        12'b110000_100000,  // R2 oc on tick edge
        12'b000000_000000,  // R3 second hit counted, no trip
        12'b100000_000000,  // R3 clean cycle
        12'b101000_000000,  // R7 single negative cycle
        12'b100000_000000   // R7 count cleared
    };

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step(input logic t, input logic o, input logic n,
                        input logic r, input logic h, input logic d);
        @(negedge clk);
        cyc_tick = t; oc_flag = o; neg_flag = n; in_reg = r; ot_flag = h; ss_done = d;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cyc_tick = 0; oc_flag = 0; neg_flag = 0; in_reg = 0; ot_flag = 0; ss_done = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        do_reset();
        check("R1 reset state", outs(), 6'b000010);
        for (int i = 0; i < 10; i++) begin
            step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
            check($sformatf("table %0d", i), outs(), VEC[i][5:0]);
        end

        // R3: 16 hits, clean cycle, 16 hits -> no shutdown
        do_reset();
        step(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < OC_N - 1; i++) step(1, 1, 0, 0, 0, 0);
        check("R3 sixteen hits no trip", {5'b0, all_off}, 6'd0);
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < OC_N - 1; i++) step(1, 1, 0, 0, 0, 0);
        check("R3 count cleared by clean cycle", {5'b0, all_off}, 6'd0);

        // R4: 17th consecutive hit trips
        step(1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        check("R4 shutdown on 17th", outs(), 6'b110001);

        // R5: hiccup wait length, then restart pulse
        for (int i = 0; i < WAIT_N - 2; i++) step(0, 0, 0, 0, 0, 0);
        check("R5 still waiting", outs(), 6'b110001);
        step(0, 0, 0, 0, 0, 0);
        check("R5 restart pulse", outs(), 6'b000110);
        step(0, 0, 0, 0, 0, 0);
        check("R5 pulse one clock", outs(), 6'b000010);

        // R11: fresh count after retry
        for (int i = 0; i < OC_N - 1; i++) step(1, 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        check("R11 no trip after retry", outs(), 6'b000010);

        // R7: negative current ignored during soft-start
        for (int i = 0; i < NEG_N + 1; i++) step(1, 0, 1, 0, 0, 0);
        check("R7 neg ignored in soft-start", outs(), 6'b000010);
        step(0, 0, 0, 0, 0, 1);
        check("R6 run after ss_done", outs(), 6'b000000);

        // R7: 3, gap, 3 -> no trip; one more -> trip
        for (int i = 0; i < NEG_N - 1; i++) step(1, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < NEG_N - 1; i++) step(1, 0, 1, 0, 0, 0);
        check("R7 no trip on broken run", outs(), 6'b000000);
        step(1, 0, 1, 0, 0, 0);
        check("R7 neg trip discharge", outs(), 6'b111000);

        // R8: wait for regulation, then timed PFM hold
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0);
        check("R8 discharge held", outs(), 6'b111000);
        step(0, 0, 0, 1, 0, 0);
        check("R8 PFM hold start", outs(), 6'b000010);
        for (int i = 0; i < PFM_N - 1; i++) step(0, 0, 0, 1, 0, 0);
        check("R8 PFM hold last clock", outs(), 6'b000010);
        step(0, 0, 0, 1, 0, 0);
        check("R8 back to run", outs(), 6'b000000);

        // R9: over-temperature from run
        step(0, 0, 0, 0, 1, 0);
        check("R9 hot shutdown", outs(), 6'b110001);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0);
        check("R9 hot held", outs(), 6'b110001);
        step(0, 0, 0, 0, 0, 0);
        check("R9 restart on cool", outs(), 6'b000110);

        // R10: over-temperature during hiccup wait shortens it
        step(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < OC_N; i++) step(1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        check("R10 in hiccup wait", outs(), 6'b110001);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0);
        check("R10 hot in wait", outs(), 6'b110001);
        step(0, 0, 0, 0, 0, 0);
        check("R10 restart without full wait", outs(), 6'b000110);

        finish_run();
    end
endmodule